// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block generates the oscillator-level timing of an 8051-style external memory bus. A free-running phase counter splits the oscillator clock into machine cycles of 12 clocks. Within each machine cycle the block places the address-latch strobe (`ale`), the active-low code-store enable (`psen_n`), the active-low read strobe (`rd_n`) and the active-low write strobe (`wr_n`) on exact clocks. The low address byte and the data byte share one port (`lo_*`). The high address byte is driven on a second port (`hi_*`). Each port has its own output enable, so the low port stops driving whenever external memory drives it.

The CPU side uses a valid/ready request channel. `req_ready` is high only in the last clock of each machine cycle. A request that is valid in that clock is taken, and it fills the whole next machine cycle. Holding `req_valid` low in that clock leaves the next machine cycle idle. The request has no other back-pressure: a request waits until the next boundary. Returned bytes come out as a `rsp_valid` pulse with `rsp_data` and have no ready signal. The consumer must take each byte in the clock it appears.

A code fetch reads two consecutive bytes in one machine cycle, at the request address and at the address plus one, so that ALE runs at one sixth of the oscillator rate. A data read or write uses a single long strobe. That strobe takes the place of both code-store pulses and of the second ALE pulse. When `ale_inhibit` is set and no access is in progress, ALE is held low to cut emissions.

Top module: `xbus_sequencer`

## Requirements
- R1: The machine cycle is 12 clocks, numbered 0 to 11. `req_ready` is high only in clock 11, including the clock 11 held during and right after reset. A request accepted there fills the next clocks 0 to 11, with `busy` high in exactly those clocks. The address and write data are registered at acceptance, so later changes on the request inputs have no effect.
- R2: While reset is asserted, `ale` is low. `psen_n`, `rd_n` and `wr_n` are high. `lo_oe`, `hi_oe`, `busy` and `rsp_valid` are low, and `req_ready` is high.
- R3: Code fetch (kind 2'b00) produces two fetches. The first uses the request address A in clocks 0 to 5, and the second uses A+1 in clocks 6 to 11, with the carry passing into the high byte. In each six-clock slot (offsets 0 to 5), `ale` is high at offsets 0 and 1 and `psen_n` is low at offsets 3 to 5. The low port drives the slot address bits 7..0 at offsets 0 to 2 and floats at offsets 3 to 5. The high port drives the slot address bits 15..8 for all 12 clocks.
- R4: In a code fetch, the byte on `lo_in` is sampled at the rising edge that ends clock 5 and at the one that ends clock 11. Each sampled byte appears on `rsp_data` with `rsp_valid` high for one clock: clock 6, and clock 0 of the following machine cycle.
- R5: Data read (kind 2'b01): `ale` is high only in clocks 0 and 1, `rd_n` is low in clocks 5 to 10, and `psen_n` stays high. The low port drives address bits 7..0 in clocks 0 to 2 and floats in clocks 3 to 11. The byte on `lo_in` is sampled at the edge that ends clock 10 and is returned with `rsp_valid` in clock 11.
- R6: Data write (kind 2'b10): `ale` is high only in clocks 0 and 1, `wr_n` is low in clocks 5 to 10, and `psen_n` stays high. The low port drives address bits 7..0 in clocks 0 to 2, floats in clock 3 and drives the write data in clocks 4 to 11. No response is returned.
- R7: In an idle machine cycle no strobe goes low and neither port drives. `ale` pulses in clocks 0, 1, 6 and 7 when `ale_inhibit` is 0 and stays low when it is 1. `ale_inhibit` has no effect during an accepted access.
- R8: At most one of `psen_n`, `rd_n` and `wr_n` is low at a time. `ale` is never high while any of them is low. The low port never drives while `psen_n` or `rd_n` is low.
- R9: The request kind code 2'b11 behaves exactly as a code fetch.
- R10: Requests accepted in consecutive machine cycles run with no gap. `busy` stays high, and after a data strobe rises in clock 11, ALE rises again one clock later, in clock 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_inhibit | input | 1 | Hold ALE low in idle machine cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock (machine-cycle boundary) |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 fetch |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Accepted access in progress |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port value: address bits 7..0 or write data |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input from memory |
| hi_out | output | 8 | High port value: address bits 15..8 |
| hi_oe | output | 1 | High port output enable |
| rsp_valid | output | 1 | Returned byte valid, one clock |
| rsp_data | output | 8 | Returned byte |

## Verification
The assertions check on every cycle the exclusion rules: no two strobes low together, ALE clear of every strobe, and the low port released while memory drives it. They also check that `busy` only starts on clock 0, that each data strobe is low for exactly six clocks, and that every response follows a sampling strobe. Only the directed scenarios can show where each edge sits inside the machine cycle. The same holds for the address values on both ports, including the carry into the high byte on the second fetch, for which bytes are captured, and for the idle behaviour of ALE with and without the inhibit.

// File: rtl/xbus_seq_pkg.sv
`timescale 1ns/1ps
package xbus_seq_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH     = 2'd0,
    ACC_READ      = 2'd1,
    ACC_WRITE     = 2'd2,
    ACC_FETCH_ALT = 2'd3
  } acc_kind_e;

  // strobe timing in oscillator clocks
  localparam int ALE_CLKS       = 2;
  localparam int ADDR_HOLD_CLKS = 1;
  localparam int PSEN_CLKS      = 3;
  localparam int STB_DELAY_CLKS = 3;
  localparam int STB_CLKS       = 6;
endpackage

// File: rtl/xbus_seq_phase.sv
`timescale 1ns/1ps
module xbus_seq_phase #(
  parameter int CYCLE_LEN = 12,
  localparam int PH_W = $clog2(CYCLE_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_LEN - 1);

  assign last = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= PH_LAST;
    else if (last)
      phase <= '0;
    else
      phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/xbus_seq_ctl.sv
`timescale 1ns/1ps
module xbus_seq_ctl
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              active,
  output acc_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  assign req_ready = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      kind_q  <= ACC_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (last) begin
      active <= req_valid;
      if (req_valid) begin
        kind_q  <= acc_kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/xbus_seq_strobe.sv
`timescale 1ns/1ps
module xbus_seq_strobe
  import xbus_seq_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int PH_W     = $clog2(CYCLE_LEN),
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic [PH_W-1:0]   phase,
  input  logic              active,
  input  acc_kind_e         kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              ale_inhibit,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              sample_en
);
  localparam int SLOT_LEN = CYCLE_LEN / 2;
  localparam int ADDR_END = ALE_CLKS + ADDR_HOLD_CLKS - 1;
  localparam int PSEN_BEG = ALE_CLKS + ADDR_HOLD_CLKS;
  localparam int PSEN_END = PSEN_BEG + PSEN_CLKS - 1;
  localparam int STB_BEG  = ALE_CLKS + STB_DELAY_CLKS;
  localparam int STB_END  = STB_BEG + STB_CLKS - 1;
  localparam int WDAT_BEG = STB_BEG - ADDR_HOLD_CLKS;

  logic              second_half;
  logic [PH_W-1:0]   slot_pos;
  logic              is_fetch, is_read, is_write;
  logic [ADDR_W-1:0] addr_cur;
  logic              in_ale, in_psen, in_stb, slot_addr, data_addr, in_wdat;

  always_comb begin
    second_half = (phase >= PH_W'(SLOT_LEN));
    slot_pos    = second_half ? (phase - PH_W'(SLOT_LEN)) : phase;
    is_fetch    = (kind_q == ACC_FETCH) || (kind_q == ACC_FETCH_ALT);
    is_read     = (kind_q == ACC_READ);
    is_write    = (kind_q == ACC_WRITE);
    addr_cur    = (is_fetch && second_half) ? (addr_q + ADDR_W'(1)) : addr_q;

    in_ale    = (slot_pos < PH_W'(ALE_CLKS));
    slot_addr = (slot_pos <= PH_W'(ADDR_END));
    in_psen   = (slot_pos >= PH_W'(PSEN_BEG)) && (slot_pos <= PH_W'(PSEN_END));
    data_addr = (phase <= PH_W'(ADDR_END));
    in_stb    = (phase >= PH_W'(STB_BEG)) && (phase <= PH_W'(STB_END));
    in_wdat   = (phase >= PH_W'(WDAT_BEG));

    // the second ALE of a data cycle is dropped: its strobe covers that slot
    if (active)
      ale = in_ale && (is_fetch || !second_half);
    else
      ale = in_ale && !ale_inhibit;

    psen_n = !(active && is_fetch && in_psen);
    rd_n   = !(active && is_read && in_stb);
    wr_n   = !(active && is_write && in_stb);

    lo_oe  = 1'b0;
    lo_out = '0;
    if (active) begin
      if (is_fetch) begin
        lo_oe = slot_addr;
      end else if (is_read) begin
        lo_oe = data_addr;
      end else begin
        lo_oe = data_addr || in_wdat;
      end
      if (lo_oe)
        lo_out = (is_write && in_wdat) ? wdata_q : addr_cur[DATA_W-1:0];
    end

    hi_oe  = active;
    hi_out = active ? addr_cur[ADDR_W-1:DATA_W] : '0;

    sample_en = active &&
                ((is_fetch && (slot_pos == PH_W'(PSEN_END))) ||
                 (is_read && (phase == PH_W'(STB_END))));
  end
endmodule

// File: rtl/xbus_seq_capture.sv
`timescale 1ns/1ps
module xbus_seq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] lo_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample_en;
      if (sample_en)
        rsp_data <= lo_in;
    end
  end
endmodule

// File: rtl/xbus_sequencer.sv
`timescale 1ns/1ps
module xbus_sequencer
  import xbus_seq_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int PH_W     = $clog2(CYCLE_LEN),
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_inhibit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  input  logic [DATA_W-1:0] lo_in,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [PH_W-1:0]   phase;
  logic              last;
  logic              active;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sample_en;

  xbus_seq_phase #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
  );

  xbus_seq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .last(last),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .active(active),
    .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  xbus_seq_strobe #(.CYCLE_LEN(CYCLE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .phase(phase), .active(active), .kind_q(kind_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .ale_inhibit(ale_inhibit), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
    .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe), .sample_en(sample_en)
  );

  xbus_seq_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .lo_in(lo_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign busy = active;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~psen_n, ~rd_n, ~wr_n})); // R8
  AST_ALE_CLEAR_OF_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R8
  AST_PORT_FLOATS_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !lo_oe); // R8
  AST_BUSY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == '0)); // R1
  AST_RD_SIX_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> ($past(!rd_n, 6) && $past(rd_n, 7))); // R5
  AST_WR_SIX_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ($past(!wr_n, 6) && $past(wr_n, 7))); // R6
  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!psen_n || !rd_n)); // R4
endmodule

// File: tb/test_xbus_sequencer.sv
`timescale 1ns/1ps
module test_xbus_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale_inhibit = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        busy, ale, psen_n, rd_n, wr_n, lo_oe, hi_oe, rsp_valid;
  logic [7:0]  lo_out, hi_out, rsp_data;
  logic [7:0]  lo_in = 8'h0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  pend_v = 1'b0;
  logic [7:0] pend_d = 8'h0;

  always #2.5 clk = ~clk;

  xbus_sequencer i_xbus_sequencer (
    .clk(clk), .rst_n(rst_n), .ale_inhibit(ale_inhibit),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
    .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out), .hi_oe(hi_oe),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string what, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Runs one machine cycle. Entered just after the falling edge of clock 11.
  task automatic run_mc(input bit act, input logic [1:0] kind,
                        input logic [15:0] addr, input logic [7:0] wdata,
                        input bit inh, input logic [7:0] pat, input string tag);
    bit fetch, rd, wr;
    bit nxt_v;
    logic [7:0] nxt_d;
    fetch = act && (kind == 2'd0 || kind == 2'd3);
    rd    = act && (kind == 2'd1);
    wr    = act && (kind == 2'd2);
    nxt_v = 1'b0;
    nxt_d = 8'h0;
    ale_inhibit = inh;
    req_valid = act;
    req_kind  = kind;
    req_addr  = addr;
    req_wdata = wdata;
    for (int k = 0; k < 12; k++) begin
      int q;
      logic [15:0] a2;
      bit e_ale, e_psen, e_rd, e_wr, e_oe, e_rv;
      logic [7:0] e_lo, e_rd_data;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~addr;
      req_wdata = ~wdata;
      lo_in     = pat ^ 8'(k);
      #1;
      q      = k % 6;
      a2     = (fetch && k >= 6) ? addr + 16'd1 : addr;
      e_ale  = (q < 2) && (act ? (fetch || k < 6) : !inh);
      e_psen = !(fetch && q >= 3);
      e_rd   = !(rd && k >= 5 && k <= 10);
      e_wr   = !(wr && k >= 5 && k <= 10);
      e_oe   = act && (fetch ? (q < 3) : rd ? (k < 3) : (k < 3 || k >= 4));
      e_lo   = (wr && k >= 4) ? wdata : a2[7:0];
      if (k == 0) begin
        e_rv = pend_v; e_rd_data = pend_d;
      end else begin
        e_rv = (fetch && k == 6) || (rd && k == 11);
        e_rd_data = pat ^ ((k == 6) ? 8'd5 : 8'd10);
      end
      chk("ale", tag, 16'(ale), 16'(e_ale));
      chk("psen_n", tag, 16'(psen_n), 16'(e_psen));
      chk("rd_n", tag, 16'(rd_n), 16'(e_rd));
      chk("wr_n", tag, 16'(wr_n), 16'(e_wr));
      chk("lo_oe", tag, 16'(lo_oe), 16'(e_oe));
      if (e_oe) chk("lo_out", tag, 16'(lo_out), 16'(e_lo));
      chk("hi_oe", tag, 16'(hi_oe), 16'(act));
      if (act) chk("hi_out", tag, 16'(hi_out), 16'(a2[15:8]));
      chk("busy", "R1", 16'(busy), 16'(act));
      chk("req_ready", "R1", 16'(req_ready), 16'(k == 11));
      chk("rsp_valid", fetch ? "R4" : tag, 16'(rsp_valid), 16'(e_rv));
      if (e_rv) chk("rsp_data", fetch ? "R4" : tag, 16'(rsp_data), 16'(e_rd_data));
      chk("strobes exclusive", "R8",
          16'(int'(!psen_n) + int'(!rd_n) + int'(!wr_n) > 1), 16'd0);
      chk("no drive during input strobe", "R8",
          16'(lo_oe && (!psen_n || !rd_n)), 16'd0);
    end
    if (fetch) begin
      nxt_v = 1'b1;
      nxt_d = pat ^ 8'd11;
    end
    pend_v = nxt_v;
    pend_d = nxt_d;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    #1;
    chk("ale", "R2", 16'(ale), 16'd0);
    chk("strobes", "R2", 16'({psen_n, rd_n, wr_n}), 16'd7);
    chk("oe", "R2", 16'({lo_oe, hi_oe}), 16'd0);
    chk("busy", "R2", 16'(busy), 16'd0);
    chk("rsp_valid", "R2", 16'(rsp_valid), 16'd0);
    chk("req_ready", "R2", 16'(req_ready), 16'd1);
    rst_n = 1'b1;
    #1;
    chk("req_ready after reset", "R1", 16'(req_ready), 16'd1);
  endtask

  task automatic t_idle_free;     run_mc(0, 2'd0, 16'h0, 8'h0, 0, 8'h00, "R7"); endtask
  task automatic t_idle_inhibit;  run_mc(0, 2'd0, 16'h0, 8'h0, 1, 8'h00, "R7"); endtask
  task automatic t_fetch;         run_mc(1, 2'd0, 16'h12FF, 8'h0, 0, 8'h3C, "R3"); endtask
  task automatic t_read;          run_mc(1, 2'd1, 16'hA55A, 8'h0, 0, 8'h96, "R5"); endtask
  task automatic t_write;         run_mc(1, 2'd2, 16'h7E81, 8'hC3, 0, 8'h11, "R6"); endtask
  task automatic t_fetch_inhibit; run_mc(1, 2'd0, 16'h0400, 8'h0, 1, 8'h5A, "R7"); endtask
  task automatic t_kind3;         run_mc(1, 2'd3, 16'hFFFF, 8'h0, 0, 8'hE7, "R9"); endtask
  task automatic t_back_to_back;
    run_mc(1, 2'd1, 16'h0102, 8'h00, 1, 8'h48, "R10");
    run_mc(1, 2'd2, 16'h0304, 8'hA9, 1, 8'h00, "R10");
    run_mc(1, 2'd0, 16'h0506, 8'h00, 1, 8'h71, "R10");
    run_mc(1, 2'd1, 16'h0708, 8'h00, 0, 8'h2D, "R10");
  endtask

  initial begin
    t_reset();
    t_idle_free();
    t_idle_inhibit();
    t_fetch();
    t_read();
    t_write();
    t_fetch_inhibit();
    t_kind3();
    t_idle_free();
    t_back_to_back();
    t_idle_inhibit();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule